// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is an iterative integer multiply and divide engine that works beside a processor pipeline. The pipeline hands it a command: one of four operations on two 32-bit operands. The engine then works in the background, one operand bit per clock cycle, while the pipeline keeps advancing. The result goes into two dedicated result registers. A multiply places the high half of the 64-bit product in HI and the low half in LO. A divide places the quotient in LO and the remainder in HI.

The pipeline reads HI or LO through a small read port with a valid/ready handshake. While a computation is still in progress, ready is held low, so a read issued too early stalls until the result is in place. The command port never pushes back. A new command is always taken, and if one is already running, the running one is dropped without writing anything. Operand width is a parameter with a default of 32, and the latency follows from it.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` is 0 and both HI and LO read as zero.
- R2: `cmd_ready` is always 1, and a command is taken on every clock edge where `cmd_valid` is 1; `busy` is 1 in the cycle after any taken command.
- R3: After the edge that takes a command, `busy` stays 1 for exactly 33 cycles (operand width plus one). HI and LO are written on the edge that clears `busy`.
- R4: Opcode 2'b00 is a signed multiply. HI receives bits 63..32 and LO receives bits 31..0 of the two's complement product.
- R5: Opcode 2'b01 is an unsigned multiply, with the same split of the 64-bit product into HI and LO.
- R6: Opcode 2'b10 is a signed divide. LO gets the quotient rounded toward zero, and HI gets the remainder, which carries the sign of the dividend.
- R7: Opcode 2'b11 is an unsigned divide, with the quotient in LO and the remainder in HI.
- R8: Division by zero raises no error and keeps the normal latency. For an unsigned divide by zero, LO becomes all ones and HI becomes the dividend.
- R9: Read port: `rd_sel` = 0 selects LO and `rd_sel` = 1 selects HI. `rd_ready` equals the inverse of `busy`, and a read completes only in a cycle where both `rd_valid` and `rd_ready` are 1.
- R10: `rd_data` always shows the selected register. While an operation runs, HI and LO keep the previous result.
- R11: A command taken while `busy` is 1 drops the running operation, which never writes HI or LO. The new result appears 33 cycles after the new command is taken.
- R12: The signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_a | input | 32 | Multiplicand or dividend |
| cmd_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 1 | 0 reads LO, 1 reads HI |
| rd_ready | output | 1 | Read may complete this cycle |
| rd_data | output | 32 | Selected result register |

## Verification
The multiply is tried with small positive operands, with mixed signs, and with both operands at the most negative value. It is also tried unsigned with all-ones and wide random-looking operands. Together these separate a correct sign correction from a bare magnitude product and show whether the carry reaches the high half. The divide is tried with all four sign combinations of a dividend and divisor that do not divide evenly. This tells truncation toward zero and a dividend-signed remainder apart from floor-style division. A zero divisor, the signed overflow pair, and an unsigned divisor larger than the dividend cover the edges of the restoring loop. Separate directed sequences check the latency count, the stalled read, the held old result, and abort-and-restart.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ITER = 2'b01,
    PH_FIN  = 2'b10
  } md_phase_e;
endpackage

// File: rtl/md_sequencer.sv
module md_sequencer #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic step,
  output logic finish
);
  import muldiv_pkg::*;
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  md_phase_e      phase_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      phase_q <= PH_ITER;
      cnt_q   <= CW'(W - 1);
    end else begin
      case (phase_q)
        PH_ITER: begin
          if (cnt_q == '0) phase_q <= PH_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_FIN:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign step   = (phase_q == PH_ITER) && !start;
  assign finish = (phase_q == PH_FIN) && !start;

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_idle_only_via_fin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (busy || $past(phase_q == PH_FIN)));
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     acc;

  always_comb begin
    acc = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod_q  <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod_q  <= {acc, prod_q[W-1:1]};
    end
  end

  assign prod = prod_q;

  // R11: no movement in the datapath without a load or step from the sequencer
  assert_mul_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(prod_q));
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] dvs_q, quo_q, rem_q;
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = !trial[W+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      dvs_q <= dvs_in;
      quo_q <= dvd_in;
      rem_q <= '0;
    end else if (step) begin
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

  assert_rem_below_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dvs_q != '0 && rem_q < dvs_q) |=> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  input  logic         rd_valid,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  import muldiv_pkg::*;

  logic           start, step, finish;
  logic           is_signed, a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;
  logic           is_div_q, neg_main_q, neg_rem_q;
  logic [W-1:0]   hi_q, lo_q;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0]   quo, rem;

  assign cmd_ready = 1'b1;
  assign start     = cmd_valid;

  always_comb begin
    is_signed = (cmd_op == OP_MUL) || (cmd_op == OP_DIV);
    a_neg     = is_signed && cmd_a[W-1];
    b_neg     = is_signed && cmd_b[W-1];
    a_mag     = a_neg ? (~cmd_a + 1'b1) : cmd_a;
    b_mag     = b_neg ? (~cmd_b + 1'b1) : cmd_b;
  end

  md_sequencer #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .step(step), .finish(finish)
  );

  md_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step),
    .mcand_in(a_mag), .mplier_in(b_mag), .prod(prod)
  );

  md_div_core #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step),
    .dvd_in(a_mag), .dvs_in(b_mag), .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (start) begin
      is_div_q   <= cmd_op[1];
      neg_main_q <= a_neg ^ b_neg;
      neg_rem_q  <= a_neg;
    end
  end

  assign prod_fix = neg_main_q ? (~prod + 1'b1) : prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish) begin
      if (is_div_q) begin
        lo_q <= neg_main_q ? (~quo + 1'b1) : quo;
        hi_q <= neg_rem_q  ? (~rem + 1'b1) : rem;
      end else begin
        hi_q <= prod_fix[2*W-1:W];
        lo_q <= prod_fix[W-1:0];
      end
    end
  end

  assign rd_ready = !busy;
  assign rd_data  = rd_sel ? hi_q : lo_q;

  assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> ($stable(hi_q) && $stable(lo_q)));

  assert_restart_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (busy && !finish));

  assert_read_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |-> !busy);
endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy;
  logic        rd_valid = 1'b0;
  logic        rd_sel = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  muldiv_unit #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  localparam int NV = 13;
  localparam logic [65:0] VEC [NV] = '{
    {2'b00, 32'd7,        32'd6},
    {2'b00, 32'hFFFFFFFD, 32'd5},
    {2'b00, 32'h80000000, 32'h80000000},
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b01, 32'h12345678, 32'h9ABCDEF0},
    {2'b10, 32'd100,      32'd7},
    {2'b10, 32'hFFFFFF9C, 32'd7},
    {2'b10, 32'd100,      32'hFFFFFFF9},
    {2'b10, 32'hFFFFFF9C, 32'hFFFFFFF9},
    {2'b10, 32'h80000000, 32'hFFFFFFFF},
    {2'b11, 32'hFFFFFFFF, 32'd16},
    {2'b11, 32'd5,        32'd0},
    {2'b11, 32'd7,        32'd9}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin p = 64'(sa * sb); model = p; end
      2'b01: begin p = {32'b0, a} * {32'b0, b}; model = p; end
      2'b10: begin q = sa / sb; r = sa % sb; model = {r[31:0], q[31:0]}; end
      default: begin
        if (b == 0) model = {a, 32'hFFFFFFFF};
        else        model = {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'b00: tag = "R4";
      2'b01: tag = "R5";
      2'b10: tag = (a == 32'h80000000 && b == 32'hFFFFFFFF) ? "R12" : "R6";
      default: tag = (b == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (busy && lat < 100) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] val);
    rd_valid = 1'b1; rd_sel = sel;
    #1;
    val = rd_data;
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] exp;
    int lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    read_reg(1'b0, v); chk("R1 LO", v, 32'd0);
    read_reg(1'b1, v); chk("R1 HI", v, 32'd0);
    chk("R2 cmd_ready idle", {31'b0, cmd_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      {op, a, b} = VEC[i];
      exp = model(op, a, b);
      issue(op, a, b);
      chk("R2 busy after take", {31'b0, busy}, 32'd1);
      wait_done(lat);
      chk("R3 latency", lat, 32'd33);
      chk("R9 ready after done", {31'b0, rd_ready}, 32'd1);
      read_reg(1'b0, v); chk({tag(op, a, b), " LO"}, v, exp[31:0]);
      read_reg(1'b1, v); chk({tag(op, a, b), " HI"}, v, exp[63:32]);
    end

    // R8 signed divide by zero: no error, normal latency
    issue(2'b10, 32'hFFFFFF00, 32'd0);
    wait_done(lat);
    chk("R8 signed div0 latency", lat, 32'd33);

    // known result first: 6*7 = 42
    issue(2'b01, 32'd6, 32'd7);
    wait_done(lat);
    // R9 / R10: start a divide, probe mid-run
    issue(2'b11, 32'd1000, 32'd3);
    repeat (10) @(negedge clk);
    chk("R9 ready low while busy", {31'b0, rd_ready}, 32'd0);
    read_reg(1'b0, v); chk("R10 old LO held", v, 32'd42);
    read_reg(1'b1, v); chk("R10 old HI held", v, 32'd0);
    chk("R2 cmd_ready while busy", {31'b0, cmd_ready}, 32'd1);
    // R11 abort and restart with 3*4
    issue(2'b01, 32'd3, 32'd4);
    wait_done(lat);
    chk("R11 restart latency", lat, 32'd33);
    read_reg(1'b0, v); chk("R11 LO from new op", v, 32'd12);
    read_reg(1'b1, v); chk("R11 HI from new op", v, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule